// File: doc/BRIEF.md
# Single-Operand Shift and Extend Unit

This is the combinational execute slice for the one-operand data operations of a 16-bit RISC core. A 3-bit sub-opcode picks one of four data operations. These are a right rotate through the carry, an arithmetic right rotate, a byte swap and a sign extension. The unit returns the result, new C, Z, N and V flags, and a strobe that tells the status register whether to take those flags.

The same sub-opcode field also encodes the three stack and flow operations: push, call and return from interrupt. This unit only recognises them and raises `unhandled_o` so that the sequencer can take over. The eighth code is raised as illegal. Operand fetch and write-back sit outside the unit. The operand arrives already read, together with the instruction's byte/word bit and the current carry.

Top module: `single_op_unit`

## Requirements
- R1: Sub-opcode codes are 000 rotate through carry, 001 swap bytes, 010 arithmetic rotate, 011 sign extend, 100 push, 101 call, 110 return from interrupt, and 111 illegal. Codes 100 to 110 raise `unhandled_o` and code 111 raises `illegal_o`. At most one of `flag_we_o`, `unhandled_o` and `illegal_o` is high.
- R2: Rotate through carry shifts the operand right by one and places the incoming carry in the MSB. The MSB is bit 15 when `byte_i`=0 and bit 7 when `byte_i`=1.
- R3: Arithmetic rotate shifts right by one and keeps the MSB (bit 15 for word, bit 7 for byte) at its old value.
- R4: Both rotates set `c_o` to the operand's bit 0 and raise `flag_we_o`.
- R5: In byte mode (`byte_i`=1), the rotates return bits 15..8 of the result as zero, whatever the operand's upper byte holds.
- R6: Swap bytes returns {operand[7:0], operand[15:8]}. `byte_i` has no effect on it.
- R7: Sign extend returns operand[7:0] with bit 7 copied into bits 15..8. `byte_i` has no effect on it.
- R8: For the rotates and sign extend, `n_o` is the result's MSB at the operating width, `z_o` is high when the result at that width is zero, and `v_o` is 0. Sign extend always operates at word width.
- R9: Sign extend sets `c_o` to the inverse of `z_o`.
- R10: Swap bytes leaves the flags untouched: `flag_we_o`=0 and all four flag outputs are 0.
- R11: For the unhandled and illegal codes, `result_o` is 0, `flag_we_o` is 0 and all four flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| subop_i | input | 3 | Operation sub-opcode |
| byte_i | input | 1 | 1 = byte operation, 0 = word operation |
| carry_i | input | 1 | Current carry flag |
| operand_i | input | 16 | Operand value |
| result_o | output | 16 | Operation result |
| c_o | output | 1 | New carry flag |
| z_o | output | 1 | New zero flag |
| n_o | output | 1 | New negative flag |
| v_o | output | 1 | New overflow flag |
| flag_we_o | output | 1 | Status register should load the four flags |
| unhandled_o | output | 1 | Stack/flow code, to be sequenced elsewhere |
| illegal_o | output | 1 | Reserved code 111 |

## Verification
The assertions assume that every input holds a known 0/1 value. They sample a settled combinational output for the inputs presented, so the operand, carry, byte bit and sub-opcode must change together and not in separate steps. The bench drives all four inputs in a single step on the rising edge and samples half a period later. It begins with a fixed set of operands chosen to exercise both byte lanes, sign boundaries, zero results and carry in and out, then continues with random words that cover all eight sub-opcodes in both widths.

// File: rtl/sou_pkg.sv
package sou_pkg;
  typedef enum logic [2:0] {
    OP_RRC  = 3'b000,
    OP_SWAP = 3'b001,
    OP_RRA  = 3'b010,
    OP_SEXT = 3'b011,
    OP_PUSH = 3'b100,
    OP_CALL = 3'b101,
    OP_RETI = 3'b110,
    OP_ILL  = 3'b111
  } subop_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flags_t;
endpackage

// File: rtl/sou_decode.sv
module sou_decode
  import sou_pkg::*;
(
  input  logic [2:0] subop_i,
  output subop_e     op_o,
  output logic       is_rot_o,
  output logic       is_arith_o,
  output logic       is_perm_o,
  output logic       is_sext_o,
  output logic       unhandled_o,
  output logic       illegal_o
);
  always_comb begin
    op_o        = subop_e'(subop_i);
    is_rot_o    = 1'b0;
    is_arith_o  = 1'b0;
    is_perm_o   = 1'b0;
    is_sext_o   = 1'b0;
    unhandled_o = 1'b0;
    illegal_o   = 1'b0;
    unique case (op_o)
      OP_RRC:                    is_rot_o = 1'b1;
      OP_RRA: begin
        is_rot_o   = 1'b1;
        is_arith_o = 1'b1;
      end
      OP_SWAP:                   is_perm_o = 1'b1;
      OP_SEXT: begin
        is_perm_o = 1'b1;
        is_sext_o = 1'b1;
      end
      OP_PUSH, OP_CALL, OP_RETI: unhandled_o = 1'b1;
      default:                   illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sou_rotate.sv
module sou_rotate #(
  parameter int W = 16
) (
  input  logic [W-1:0] opnd_i,
  input  logic         byte_i,
  input  logic         arith_i,
  input  logic         carry_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  localparam int H = W / 2;

  logic fill_word, fill_byte;

  // Bit shifted into the vacated MSB at each width
  assign fill_word = arith_i ? opnd_i[W-1] : carry_i;
  assign fill_byte = arith_i ? opnd_i[H-1] : carry_i;

  always_comb begin
    if (byte_i) res_o = {{H{1'b0}}, fill_byte, opnd_i[H-1:1]};
    else        res_o = {fill_word, opnd_i[W-1:1]};
  end

  assign c_o = opnd_i[0];
endmodule

// File: rtl/sou_perm.sv
module sou_perm #(
  parameter int W = 16
) (
  input  logic [W-1:0] opnd_i,
  input  logic         sext_i,
  output logic [W-1:0] res_o
);
  localparam int H = W / 2;

  logic [W-1:0] swapped, extended;

  for (genvar g = 0; g < H; g++) begin : g_lane
    assign swapped[g]     = opnd_i[g+H];
    assign swapped[g+H]   = opnd_i[g];
    assign extended[g]    = opnd_i[g];
    assign extended[g+H]  = opnd_i[H-1];
  end

  assign res_o = sext_i ? extended : swapped;
endmodule

// File: rtl/sou_flags.sv
module sou_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0] res_i,
  input  logic         narrow_i,
  output logic         z_o,
  output logic         n_o
);
  localparam int H = W / 2;

  assign n_o = narrow_i ? res_i[H-1] : res_i[W-1];
  assign z_o = narrow_i ? (res_i[H-1:0] == '0) : (res_i == '0);
endmodule

// File: rtl/single_op_unit.sv
module single_op_unit
  import sou_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   subop_i,
  input  logic         byte_i,
  input  logic         carry_i,
  input  logic [W-1:0] operand_i,
  output logic [W-1:0] result_o,
  output logic         c_o,
  output logic         z_o,
  output logic         n_o,
  output logic         v_o,
  output logic         flag_we_o,
  output logic         unhandled_o,
  output logic         illegal_o
);
  subop_e       op;
  logic         is_rot, is_arith, is_perm, is_sext;
  logic [W-1:0] rot_res, perm_res, sel_res;
  logic         rot_c, fz, fn;
  flags_t       flags;

  sou_decode u_dec (
    .subop_i    (subop_i),
    .op_o       (op),
    .is_rot_o   (is_rot),
    .is_arith_o (is_arith),
    .is_perm_o  (is_perm),
    .is_sext_o  (is_sext),
    .unhandled_o(unhandled_o),
    .illegal_o  (illegal_o)
  );

  sou_rotate #(.W(W)) u_rot (
    .opnd_i (operand_i),
    .byte_i (byte_i),
    .arith_i(is_arith),
    .carry_i(carry_i),
    .res_o  (rot_res),
    .c_o    (rot_c)
  );

  sou_perm #(.W(W)) u_perm (
    .opnd_i(operand_i),
    .sext_i(is_sext),
    .res_o (perm_res)
  );

  always_comb begin
    if (is_rot)       sel_res = rot_res;
    else if (is_perm) sel_res = perm_res;
    else              sel_res = '0;
  end

  // Sign extend always judged at full width
  sou_flags #(.W(W)) u_flg (
    .res_i   (sel_res),
    .narrow_i(byte_i & is_rot),
    .z_o     (fz),
    .n_o     (fn)
  );

  always_comb begin
    flags     = '0;
    flag_we_o = 1'b0;
    if (is_rot) begin
      flags     = '{c: rot_c, z: fz, n: fn, v: 1'b0};
      flag_we_o = 1'b1;
    end else if (is_sext) begin
      flags     = '{c: ~fz, z: fz, n: fn, v: 1'b0};
      flag_we_o = 1'b1;
    end
  end

  assign result_o = sel_res;
  assign c_o      = flags.c;
  assign z_o      = flags.z;
  assign n_o      = flags.n;
  assign v_o      = flags.v;

  logic unused_op;
  assign unused_op = ^op;
endmodule

// File: rtl/single_op_unit_chk.sv
module single_op_unit_chk #(
  parameter int W = 16
) (
  input logic [2:0]   subop_i,
  input logic         byte_i,
  input logic         carry_i,
  input logic [W-1:0] operand_i,
  input logic [W-1:0] result_o,
  input logic         c_o,
  input logic         z_o,
  input logic         n_o,
  input logic         v_o,
  input logic         flag_we_o,
  input logic         unhandled_o,
  input logic         illegal_o
);
  localparam int H = W / 2;

  always_comb begin
    p_one_status_r1: assert ($onehot0({flag_we_o, unhandled_o, illegal_o}));
    if (subop_i == 3'b111)
      p_illegal_code_r1: assert (illegal_o);
    if (subop_i == 3'b000 && !byte_i)
      p_rrc_msb_r2: assert (result_o[W-1] == carry_i);
    if (subop_i == 3'b000 && byte_i)
      p_rrc_msb_byte_r2: assert (result_o[H-1] == carry_i);
    if (subop_i == 3'b010 && !byte_i)
      p_rra_keep_r3: assert (result_o[W-1] == operand_i[W-1]);
    if (subop_i == 3'b010 && byte_i)
      p_rra_keep_byte_r3: assert (result_o[H-1] == operand_i[H-1]);
    if ((subop_i == 3'b000 || subop_i == 3'b010))
      p_rot_carry_r4: assert (flag_we_o && c_o == operand_i[0]);
    if ((subop_i == 3'b000 || subop_i == 3'b010) && byte_i)
      p_byte_upper_r5: assert (result_o[W-1:H] == '0);
    if (subop_i == 3'b001)
      p_swap_r6: assert (result_o == {operand_i[H-1:0], operand_i[W-1:H]});
    if (subop_i == 3'b011)
      p_sext_r7: assert (result_o[H-1:0] == operand_i[H-1:0] &&
                         result_o[W-1:H] == {H{operand_i[H-1]}});
    if (flag_we_o)
      p_v_clear_r8: assert (!v_o && (z_o == (byte_i && subop_i != 3'b011 ?
                            result_o[H-1:0] == '0 : result_o == '0)));
    if (subop_i == 3'b011)
      p_sext_carry_r9: assert (c_o == !z_o);
    if (subop_i == 3'b001)
      p_swap_noflag_r10: assert (!flag_we_o && {c_o, z_o, n_o, v_o} == 4'b0);
    if (unhandled_o || illegal_o)
      p_quiet_r11: assert (result_o == '0 && !flag_we_o && {c_o, z_o, n_o, v_o} == 4'b0);
  end
endmodule

bind single_op_unit single_op_unit_chk #(.W(W)) u_chk (
  .subop_i    (subop_i),
  .byte_i     (byte_i),
  .carry_i    (carry_i),
  .operand_i  (operand_i),
  .result_o   (result_o),
  .c_o        (c_o),
  .z_o        (z_o),
  .n_o        (n_o),
  .v_o        (v_o),
  .flag_we_o  (flag_we_o),
  .unhandled_o(unhandled_o),
  .illegal_o  (illegal_o)
);

// File: tb/single_op_unit_tb.sv
module single_op_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  subop;
  logic        byt, cin;
  logic [15:0] opnd;
  logic [15:0] res;
  logic        c, z, n, v, we, unh, ill;
  int          n_checks = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  single_op_unit u_dut (
    .subop_i(subop), .byte_i(byt), .carry_i(cin), .operand_i(opnd),
    .result_o(res), .c_o(c), .z_o(z), .n_o(n), .v_o(v),
    .flag_we_o(we), .unhandled_o(unh), .illegal_o(ill)
  );

  // Behavioural reference: packs {res, c, z, n, v, we, unh, ill}
  function automatic logic [22:0] model(int s, int b, int ci, int x);
    int r = 0, fc = 0, fz = 0, fn = 0, fwe = 0, fu = 0, fi = 0;
    int lo = x % 256, hi = x / 256;
    case (s)
      0: begin
        if (b != 0) r = ci * 128 + lo / 2;
        else        r = ci * 32768 + x / 2;
        fc = x % 2; fwe = 1;
      end
      2: begin
        if (b != 0) r = (lo / 128) * 128 + lo / 2;
        else        r = (x / 32768) * 32768 + x / 2;
        fc = x % 2; fwe = 1;
      end
      1: r = lo * 256 + hi;
      3: begin
        r = (lo >= 128) ? 65280 + lo : lo;
        fwe = 1;
      end
      4, 5, 6: fu = 1;
      default: fi = 1;
    endcase
    if (fwe != 0) begin
      if (s != 3 && b != 0) begin fz = (r % 256 == 0); fn = (r % 256 >= 128); end
      else                  begin fz = (r == 0);       fn = (r >= 32768);     end
      if (s == 3) fc = (fz == 0);
    end
    return {r[15:0], fc[0], fz[0], fn[0], 1'b0, fwe[0], fu[0], fi[0]};
  endfunction

  function automatic string req_of(int s, int b);
    case (s)
      0: return b != 0 ? "R5/R2" : "R2/R4";
      2: return b != 0 ? "R5/R3" : "R3/R8";
      1: return "R6/R10";
      3: return "R7/R9";
      7: return "R1/R11";
      default: return "R1";
    endcase
  endfunction

  task automatic apply(input int s, input int b, input int ci, input int x);
    logic [22:0] exp_v, act_v;
    @(posedge clk);
    subop = s[2:0]; byt = b[0]; cin = ci[0]; opnd = x[15:0];
    @(negedge clk);
    exp_v = model(s, b, ci, x);
    act_v = {res, c, z, n, v, we, unh, ill};
    n_checks++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s sub=%0d byte=%0d cin=%0d op=%h act=%h exp=%h",
               req_of(s, b), s, b, ci, x, act_v, exp_v);
    end
  endtask

  initial begin
    subop = 3'b000; byt = 1'b0; cin = 1'b0; opnd = 16'h0000;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // Reset state: word RRC of zero gives zero result, Z set (R8)
    n_checks++;
    if ({res, c, z, n, v, we} !== {16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}) begin
      n_fail++;
      $display("FAIL R8 reset act=%h exp=%h", {res, c, z, n, v, we}, 21'h000009);
    end
    // R2 R4: carry into MSB, LSB out
    apply(0, 0, 1, 16'h0001);
    apply(0, 0, 0, 16'h8001);
    apply(0, 1, 1, 16'hFF02);  // R5 upper cleared
    // R3: MSB kept
    apply(2, 0, 0, 16'h8000);
    apply(2, 1, 1, 16'h7F81);  // R5 byte sign bit 7
    apply(2, 1, 0, 16'h0001);  // zero byte result
    // R6 R10: swap ignores byte_i and carry
    apply(1, 0, 1, 16'h12AB);
    apply(1, 1, 0, 16'h0000);
    // R7 R9: sign extend
    apply(3, 0, 0, 16'h0080);
    apply(3, 1, 1, 16'hFF7F);
    apply(3, 0, 1, 16'hAB00);  // zero result, C=0
    // R1 R11: stack and illegal codes
    for (int s = 4; s < 8; s++) apply(s, s % 2, 1, 16'hFFFF);
    for (int i = 0; i < 4000; i++)
      apply($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 65535));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule